// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed 8-bit values on a grid of multiply-accumulate cells. The second operand (the weights) is written into the grid one column per cycle and then held in place. Each cell keeps one weight for as long as the caller wants it.

Rows of the first operand are then presented on the west lanes, one whole row per cycle. Inside the block, lane k is delayed by k cycles, so every activation reaches the cell holding the weight it must meet. Activations move one cell east per cycle and partial sums move one cell south per cycle. Column c of the product leaves on south lane c as a signed 32-bit value.

Every cell's weight, activation and partial sum are exported on a flat debug bus. This lets an observer follow the dataflow cycle by cycle. Sequencing, tiling and result capture belong to the surrounding logic.

Top module: `systolic_matmul`

## Requirements
- R1: While rst_ni is low, every weight, activation, partial sum and south result reads zero, whatever the inputs do.
- R2: A clock edge with w_load_i high writes w_data_i lane r (bits r*8 +: 8) into the weight of cell (row r, column w_col_i). Cell (r,c) is exported at bus index r*4+c.
- R3: Lane r's activation reaches cell (r,c) r+c edges after it is sampled. Each cell passes its activation one column east per edge.
- R4: A lane whose act_valid_i bit is low at an edge enters a zero activation, so its act_data_i value never reaches any sum or debug activation.
- R5: At each edge, cell (r,c) stores its north neighbour's partial sum plus the signed product of its held weight and its incoming activation. Row 0 uses zero in place of the north partial sum.
- R6: A row i of A presented on all lanes at edge n yields C[i][c] = sum over k of A[i][k]*B[k][c] on res_o lane c (bits c*32 +: 32) after edge n+3+c. The value is bit-exact, including operands of -128 and 127.
- R7: A cell's weight changes only at an edge that loads its own column.
- R8: Rows may be presented on consecutive cycles with no gap, and each still yields its own correct product row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| w_load_i | input | 1 | Write one weight column this cycle |
| w_col_i | input | 2 | Column selected for the weight write |
| w_data_i | input | 32 | Weights for rows 0..3 of the selected column, 8 bits each |
| act_valid_i | input | 4 | Per-lane activation valid |
| act_data_i | input | 32 | Per-lane signed 8-bit activation, lane k at bits k*8 +: 8 |
| res_o | output | 128 | South-edge partial sums, column c at bits c*32 +: 32 |
| dbg_weight_o | output | 128 | Held weight of every cell, index r*4+c |
| dbg_act_o | output | 128 | Registered activation of every cell, index r*4+c |
| dbg_psum_o | output | 512 | Registered partial sum of every cell, index r*4+c |

## Verification
The assertions assume that reset is asserted from time zero and that the weight column index is always a legal column whenever a load is requested. The bench drives w_col_i only in the range 0 to 3 and holds rst_ni low from the first instant.

The product-level checks also assume that weights stay unchanged while any row that uses them is still inside the grid. The bench waits out a full flush after every stream before it loads new weights. A separate per-cycle model tracks weight history exactly, so the random-valid phases need no such restriction.

// File: rtl/systolic_pkg.sv
package systolic_pkg;
  localparam int unsigned SA_DIM  = 4;
  localparam int unsigned SA_DW   = 8;
  localparam int unsigned SA_AW   = 32;
endpackage

// File: rtl/sa_skew_lane.sv
module sa_skew_lane #(
  parameter int unsigned DEPTH = 0,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] gated;
  // invalid slots enter as zero so they add nothing downstream
  assign gated = valid_i ? data_i : '0;

  if (DEPTH == 0) begin : g_pass
    assign data_o = gated;
  end else begin : g_dly
    logic [DW-1:0] sr_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
      end else begin
        sr_q[0] <= gated;
        for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
      end
    end
    assign data_o = sr_q[DEPTH-1];
  end
endmodule

// File: rtl/sa_mac_cell.sv
module sa_mac_cell #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 w_we_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [DW-1:0] act_i,
  input  logic signed [AW-1:0] psum_i,
  output logic signed [DW-1:0] act_o,
  output logic signed [AW-1:0] psum_o,
  output logic signed [DW-1:0] weight_o
);
  localparam int unsigned PW = 2 * DW;

  logic signed [DW-1:0] weight_q, act_q;
  logic signed [AW-1:0] psum_q;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = weight_q * act_i;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      weight_q <= '0;
      act_q    <= '0;
      psum_q   <= '0;
    end else begin
      if (w_we_i) weight_q <= w_i;
      act_q  <= act_i;
      psum_q <= psum_i + prod_ext;
    end
  end

  assign act_o    = act_q;
  assign psum_o   = psum_q;
  assign weight_o = weight_q;
endmodule

// File: rtl/sa_mac_grid.sv
module sa_mac_grid #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      col_we_i,
  input  logic [N*DW-1:0]   w_data_i,
  input  logic [N*DW-1:0]   west_act_i,
  output logic [N*N*DW-1:0] weight_o,
  output logic [N*N*DW-1:0] act_o,
  output logic [N*N*AW-1:0] psum_o
);
  logic signed [DW-1:0] act_q  [N][N];
  logic signed [AW-1:0] psum_q [N][N];
  logic signed [DW-1:0] wgt_q  [N][N];

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int unsigned IDX = r * N + c;
      logic signed [DW-1:0] act_in;
      logic signed [AW-1:0] psum_in;

      if (c == 0) begin : g_west
        assign act_in = west_act_i[r*DW +: DW];
      end else begin : g_inner_a
        assign act_in = act_q[r][c-1];
      end

      if (r == 0) begin : g_north
        assign psum_in = '0;
      end else begin : g_inner_p
        assign psum_in = psum_q[r-1][c];
      end

      sa_mac_cell #(.DW(DW), .AW(AW)) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .w_we_i   (col_we_i[c]),
        .w_i      (w_data_i[r*DW +: DW]),
        .act_i    (act_in),
        .psum_i   (psum_in),
        .act_o    (act_q[r][c]),
        .psum_o   (psum_q[r][c]),
        .weight_o (wgt_q[r][c])
      );

      assign weight_o[IDX*DW +: DW] = wgt_q[r][c];
      assign act_o[IDX*DW +: DW]    = act_q[r][c];
      assign psum_o[IDX*AW +: AW]   = psum_q[r][c];
    end
  end
endmodule

// File: rtl/systolic_matmul.sv
module systolic_matmul
  import systolic_pkg::*;
#(
  parameter int unsigned N  = SA_DIM,
  parameter int unsigned DW = SA_DW,
  parameter int unsigned AW = SA_AW,
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              w_load_i,
  input  logic [CW-1:0]     w_col_i,
  input  logic [N*DW-1:0]   w_data_i,
  input  logic [N-1:0]      act_valid_i,
  input  logic [N*DW-1:0]   act_data_i,
  output logic [N*AW-1:0]   res_o,
  output logic [N*N*DW-1:0] dbg_weight_o,
  output logic [N*N*DW-1:0] dbg_act_o,
  output logic [N*N*AW-1:0] dbg_psum_o
);
  logic [N-1:0]    col_we;
  logic [N*DW-1:0] west_act;

  for (genvar c = 0; c < N; c++) begin : g_we
    assign col_we[c] = w_load_i && (w_col_i == CW'(c));
  end

  for (genvar k = 0; k < N; k++) begin : g_lane
    sa_skew_lane #(.DEPTH(k), .DW(DW)) u_skew (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (act_valid_i[k]),
      .data_i  (act_data_i[k*DW +: DW]),
      .data_o  (west_act[k*DW +: DW])
    );
  end

  sa_mac_grid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .col_we_i   (col_we),
    .w_data_i   (w_data_i),
    .west_act_i (west_act),
    .weight_o   (dbg_weight_o),
    .act_o      (dbg_act_o),
    .psum_o     (dbg_psum_o)
  );

  // south edge = bottom row of partial sums
  assign res_o = dbg_psum_o[(N-1)*N*AW +: N*AW];
endmodule

// File: rtl/systolic_matmul_chk.sv
module systolic_matmul_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              w_load_i,
  input logic [CW-1:0]     w_col_i,
  input logic [N*DW-1:0]   w_data_i,
  input logic [N-1:0]      act_valid_i,
  input logic [N*N*DW-1:0] dbg_weight_o,
  input logic [N*N*DW-1:0] dbg_act_o,
  input logic [N*N*AW-1:0] dbg_psum_o
);
  logic signed [DW-1:0] wt [N][N];
  logic signed [DW-1:0] ac [N][N];
  logic signed [AW-1:0] ps [N][N];

  for (genvar r = 0; r < N; r++) begin : g_r
    for (genvar c = 0; c < N; c++) begin : g_c
      assign wt[r][c] = dbg_weight_o[(r*N+c)*DW +: DW];
      assign ac[r][c] = dbg_act_o[(r*N+c)*DW +: DW];
      assign ps[r][c] = dbg_psum_o[(r*N+c)*AW +: AW];

      // R2: loaded column takes the lane data
      p_weight_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (w_load_i && w_col_i == CW'(c)) |=> wt[r][c] == $past(w_data_i[r*DW +: DW]));

      // R7: weights are stationary otherwise
      p_weight_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(w_load_i && w_col_i == CW'(c)) |=> $stable(wt[r][c]));

      if (c > 0) begin : g_east
        // R3: activation moves one column east per edge
        p_act_shift_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
          1'b1 |=> ac[r][c] == $past(ac[r][c-1]));

        if (r == 0) begin : g_top
          // R5: top row starts from zero
          p_mac_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> ps[0][c] == $signed($past(wt[0][c])) * $signed($past(ac[0][c-1])));
        end else begin : g_mid
          // R5: accumulate north partial sum
          p_mac_acc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            1'b1 |=> ps[r][c] == $signed($past(ps[r-1][c]))
                       + $signed($past(wt[r][c])) * $signed($past(ac[r][c-1])));
        end
      end
    end
  end

  // R4: invalid lane 0 enters zero (lane 0 has no delay)
  p_zero_inject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_valid_i[0] |=> ac[0][0] == '0);
endmodule

bind systolic_matmul systolic_matmul_chk #(.N(N), .DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .w_load_i     (w_load_i),
  .w_col_i      (w_col_i),
  .w_data_i     (w_data_i),
  .act_valid_i  (act_valid_i),
  .dbg_weight_o (dbg_weight_o),
  .dbg_act_o    (dbg_act_o),
  .dbg_psum_o   (dbg_psum_o)
);

// File: tb/systolic_matmul_tb_top.sv
module systolic_matmul_tb_top;
  localparam int MAXE = 4096;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         w_load = 1'b0;
  logic [1:0]   w_col = '0;
  logic [31:0]  w_data = '0;
  logic [3:0]   act_valid = '0;
  logic [31:0]  act_data = '0;
  logic [127:0] res;
  logic [127:0] dbg_w, dbg_a;
  logic [511:0] dbg_p;

  int n_chk = 0, n_fail = 0;
  int ecount = 0;
  bit done = 0;

  int xh [MAXE][4];
  int wh [MAXE+1][4][4];
  int cexp [MAXE][4];
  bit chave [MAXE][4];
  int A [4][4];
  int B [4][4];

  always #2.5 clk = ~clk;

  systolic_matmul dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .w_load_i(w_load), .w_col_i(w_col),
    .w_data_i(w_data), .act_valid_i(act_valid), .act_data_i(act_data),
    .res_o(res), .dbg_weight_o(dbg_w), .dbg_act_o(dbg_a), .dbg_psum_o(dbg_p)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int xv(input int e, input int k);
    return (e < 0) ? 0 : xh[e][k];
  endfunction

  function automatic int wv(input int e, input int r, input int c);
    return (e < 0) ? 0 : wh[e][r][c];
  endfunction

  // reference model: records what each edge sampled
  initial begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) wh[0][r][c] = 0;
  end

  always @(posedge clk) begin
    if (rst_ni && ecount < MAXE) begin
      for (int k = 0; k < 4; k++)
        xh[ecount][k] = act_valid[k] ? int'($signed(act_data[k*8 +: 8])) : 0;
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          wh[ecount+1][r][c] = (w_load && int'(w_col) == c) ?
                               int'($signed(w_data[r*8 +: 8])) : wh[ecount][r][c];
      ecount++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && ecount > 0 && !done) begin
      int e;
      bit okw, oka, okp;
      int aw, ew, aa, ea, ap, ep;
      e = ecount - 1;
      okw = 1; oka = 1; okp = 1;
      aw = 0; ew = 0; aa = 0; ea = 0; ap = 0; ep = 0;
      for (int r = 0; r < 4; r++) begin
        for (int c = 0; c < 4; c++) begin
          int idx, gw, ga, gp, xw, xa, xp;
          idx = r*4 + c;
          gw = int'($signed(dbg_w[idx*8 +: 8]));
          ga = int'($signed(dbg_a[idx*8 +: 8]));
          gp = int'($signed(dbg_p[idx*32 +: 32]));
          xw = wh[e+1][r][c];
          xa = xv(e-r-c, r);
          xp = 0;
          for (int k = 0; k <= r; k++) xp += wv(e-(r-k), k, c) * xv(e-r-c, k);
          if (gw != xw && okw) begin okw = 0; aw = gw; ew = xw; end
          if (ga != xa && oka) begin oka = 0; aa = ga; ea = xa; end
          if (gp != xp && okp) begin okp = 0; ap = gp; ep = xp; end
        end
      end
      check(okw, "R2/R7", "weight bus", aw, ew);
      check(oka, "R3/R4", "activation bus", aa, ea);
      check(okp, "R5", "partial sum bus", ap, ep);
      for (int c = 0; c < 4; c++) begin
        if (chave[e][c]) begin
          int g;
          g = int'($signed(res[c*32 +: 32]));
          check(g == cexp[e][c], "R6/R8", $sformatf("product lane %0d", c), g, cexp[e][c]);
          chave[e][c] = 0;
        end
      end
    end
  end

  task automatic load_weights();
    for (int c = 0; c < 4; c++) begin
      w_load = 1'b1;
      w_col  = 2'(c);
      for (int r = 0; r < 4; r++) w_data[r*8 +: 8] = 8'(B[r][c]);
      @(negedge clk);
    end
    w_load = 1'b0;
    w_data = $urandom;
  endtask

  // one row per cycle, no gaps (R8)
  task automatic stream_rows();
    for (int i = 0; i < 4; i++) begin
      act_valid = 4'hf;
      for (int k = 0; k < 4; k++) act_data[k*8 +: 8] = 8'(A[i][k]);
      for (int c = 0; c < 4; c++) begin
        int s;
        s = 0;
        for (int k = 0; k < 4; k++) s += A[i][k] * B[k][c];
        cexp[ecount+3+c][c] = s;
        chave[ecount+3+c][c] = 1;
      end
      @(negedge clk);
    end
  endtask

  // invalid lanes with garbage data (R4)
  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      act_valid = '0;
      act_data  = $urandom;
      @(negedge clk);
    end
  endtask

  function automatic int rnd8();
    return int'($signed(8'($urandom)));
  endfunction

  task automatic fill(input int pat);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        case (pat)
          0: begin A[r][c] = -128; B[r][c] = -128; end
          1: begin A[r][c] = 127;  B[r][c] = -128; end
          2: begin A[r][c] = ((r+c) % 2) ? 127 : -128; B[r][c] = ((r*c) % 2) ? -128 : 127; end
          default: begin A[r][c] = rnd8(); B[r][c] = rnd8(); end
        endcase
      end
  endtask

  initial begin
    for (int e = 0; e < MAXE; e++)
      for (int c = 0; c < 4; c++) chave[e][c] = 0;
    // garbage while in reset (R1)
    w_load = 1'b1; w_data = 32'hdeadbeef; act_valid = 4'hf; act_data = 32'h80807f7f;
    repeat (3) @(negedge clk);
    check(res == '0, "R1", "south result in reset", longint'(res[31:0]), 0);
    check(dbg_w == '0 && dbg_a == '0, "R1", "weight/act bus in reset",
          longint'(dbg_w[63:0]), 0);
    check(dbg_p == '0, "R1", "psum bus in reset", longint'(dbg_p[63:0]), 0);
    w_load = 1'b0; act_valid = '0; act_data = '0; w_data = '0;
    rst_ni = 1'b1;
    @(negedge clk);

    for (int t = 0; t < 24; t++) begin
      fill(t);
      load_weights();
      stream_rows();
      // second operand back to back with same weights (R8)
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++) A[r][c] = (t < 3) ? -A[r][c] - 1 : rnd8();
      stream_rows();
      idle(9);
    end

    // random per-lane valid, checked by the per-cycle model (R4, R5)
    for (int j = 0; j < 60; j++) begin
      act_valid = 4'($urandom);
      act_data  = $urandom;
      if (j % 17 == 5) begin
        w_load = 1'b1; w_col = 2'($urandom); w_data = $urandom;
      end else w_load = 1'b0;
      @(negedge clk);
    end
    w_load = 1'b0;
    idle(10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule